// File: doc/BRIEF.md
# Event Timer Register Block

This block is the register front end of a multi-channel event timer. It answers 32-bit register reads and writes on a simple request/response port. Behind that port it keeps four things: a fixed capability word, a two-bit global configuration, a status word and a 64-bit main counter. While globally enabled, the counter steps once every `TICK_DIV` clocks. When disabled it holds its value, and it resumes from that value when enabled again.

The address space above 0x100 is split into one 32-byte window per timer channel. Each window feeds a comparator channel that holds a configuration word and a 32-bit match value. A channel expires in the cycle the counter steps onto its match value. A routing stage turns each expiry into a one-clock pulse on one line of an interrupt vector. Normally the line is taken from the channel's 5-bit route field. In legacy mode, channel 0 drives lines 0 and 2 together and channel 1 drives line 8.

Top module: `evt_timer_regs`

## Requirements
- R1: A read of offset 0x000 returns 0x80868201: revision 1 in bits 7:0, the channel count minus one (2) in bits 12:8, and the legacy-route capability in bit 15. A read of 0x004 returns the tick period in femtoseconds, 0x00989680 (10,000,000).
- R2: Only bits 1:0 of the configuration register at 0x010 can be written. Bit 0 is global enable and bit 1 is legacy routing, and the register reads back as those two bits. Writes to 0x000 and 0x014 change nothing, and 0x014 reads 0.
- R3: While global enable is 1, the counter increases by one every `TICK_DIV` clocks (default 1). While it is 0, the counter holds its value, and after re-enabling it continues from the held value.
- R4: A write to 0x0F0 sets the count to the written value. A write to 0x0F4 replaces only bits 63:32 and leaves the low word unchanged. A read of 0x0F0 returns the count's low word, and a read of 0x0F4 returns 0.
- R5: Channel n lives at 0x100 + n*0x20. At +0x00, the configuration bits 2 (enable), 3 (periodic), 8 (32-bit mode) and 13:9 (route) are writable, and a read returns them with bit 4 (periodic-capable) forced to 1. +0x04 reads 0x0000FFFF. +0x08 reads and writes the match value, which resets to 0xFFFFFFFF. Windows for channel numbers of 3 or more read 0.
- R6: Undefined offsets and the status register at 0x020 read 0, and writes to them change no readable state.
- R7: When the counter steps onto a channel's match value while counting, and legacy mode is off, the channel's route line pulses high for exactly one clock.
- R8: With legacy mode on, an expiry of channel 0 pulses lines 0 and 2 together, and an expiry of channel 1 pulses line 8. Their route fields are ignored.
- R9: No line pulses unless both the channel enable and the global enable are 1. Clearing global enable before the match is reached cancels the expiry.
- R10: After reset, the configuration and counter are 0 and every line is low. Every request produces `rsp_valid` exactly one cycle later. For a read, `rsp_rdata` carries the state as it was in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset of the 32-bit register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| irq_pulse | output | 32 | One-clock interrupt pulses, one bit per line |

## Verification
The assertions assume word-aligned offsets. They also assume the counter is not written in the same cycle as a tick the bench cares about, and that a new match value is written before counting starts rather than while the counter is crossing it. The random phase keeps global enable at 0, so register traffic cannot race the counter, and it drives only aligned addresses. The interrupt tests are directed: each loads the counter and the match values while the block is disabled and then enables it. That way every expected pulse and every held count follows from the written values alone.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ADDR_W   = 10;
  localparam int ROUTE_W  = 5;

  localparam logic [ADDR_W-1:0] OFF_CAP    = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_PERIOD = 10'h004;
  localparam logic [ADDR_W-1:0] OFF_GCFG   = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_GCFG_H = 10'h014;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 10'h020;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 10'h0F4;
  localparam logic [ADDR_W-1:0] WIN_BASE   = 10'h100;

  localparam logic [4:0] WOFF_CFG   = 5'h00;
  localparam logic [4:0] WOFF_CAPS  = 5'h04;
  localparam logic [4:0] WOFF_MATCH = 5'h08;

  localparam logic [31:0] CH_WR_MASK   = 32'h0000_3F0C;
  localparam logic [31:0] CH_FIXED_ONE = 32'h0000_0010;
  localparam logic [31:0] CH_LINE_CAPS = 32'h0000_FFFF;

  // Capability word: vendor field, legacy-capable bit 15, count-1 in 12:8, revision 1.
  function automatic logic [31:0] cap_word(input int unsigned n_timers);
    logic [31:0] w;
    w = 32'h8086_0000 | 32'h0000_8000 | 32'h0000_0001;
    w = w | ((32'(n_timers - 1) & 32'h1F) << 8);
    return w;
  endfunction

  // One-hot line vector for a route number; empty when out of range.
  function automatic logic [31:0] line_bit(input logic [ROUTE_W-1:0] r);
    return 32'h1 << r;
  endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int TICK_DIV = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [63:0] cnt_q,
  output logic        tick_o,
  output logic [31:0] cnt_next_lo
);
  logic stb;

  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else if (en) div_q <= (div_q == DW'(TICK_DIV - 1)) ? '0 : div_q + 1'b1;
      end
      assign stb = en && (div_q == DW'(TICK_DIV - 1));
    end else begin : g_nodiv
      assign stb = en;
    end
  endgenerate

  assign tick_o      = stb && !wr_lo && !wr_hi;
  assign cnt_next_lo = cnt_q[31:0] + 32'd1;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (wr_lo) cnt_q <= {32'h0, wdata};
    else if (wr_hi) cnt_q[63:32] <= wdata;
    else if (tick_o) cnt_q <= cnt_q + 64'd1;
  end

  assert_freeze_R3: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_lo && !wr_hi) |=> $stable(cnt_q));
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (cnt_q == $past(cnt_q) + 64'd1));
  assert_hiwr_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> (cnt_q[31:0] == $past(cnt_q[31:0])));
endmodule

// File: rtl/evt_chan.sv
module evt_chan
  import evt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_cfg,
  input  logic        wr_match,
  input  logic [31:0] wdata,
  input  logic        tick,
  input  logic [31:0] cnt_next_lo,
  output logic [31:0] cfg_rd,
  output logic [31:0] match_q,
  output logic        expire_o,
  output logic        ten_o,
  output logic [ROUTE_W-1:0] route_o
);
  logic [31:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      match_q <= 32'hFFFF_FFFF;
    end else begin
      if (wr_cfg)   cfg_q   <= wdata & CH_WR_MASK;
      if (wr_match) match_q <= wdata;
    end
  end

  assign cfg_rd   = cfg_q | CH_FIXED_ONE;
  assign ten_o    = cfg_q[2];
  assign route_o  = cfg_q[13:9];
  assign expire_o = tick && (cnt_next_lo == match_q);

  assert_cfgmask_R5: assert property (@(posedge clk) disable iff (rst)
    ((cfg_q & ~CH_WR_MASK) == 32'h0));
  assert_noexp_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !tick |-> !expire_o);
endmodule

// File: rtl/evt_route.sv
module evt_route
  import evt_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int NUM_LINES  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_TIMERS-1:0]         expire,
  input  logic [NUM_TIMERS-1:0]         ten,
  input  logic [NUM_TIMERS*ROUTE_W-1:0] route_flat,
  input  logic                          gl_en,
  input  logic                          legacy,
  output logic [NUM_LINES-1:0]          irq_q
);
  logic [NUM_LINES-1:0]  irq_next;
  logic [NUM_TIMERS-1:0] fire;

  always_comb begin
    irq_next = '0;
    for (int t = 0; t < NUM_TIMERS; t++) begin
      fire[t] = expire[t] && ten[t] && gl_en;
      if (fire[t]) begin
        if (legacy && t == 0)      irq_next = irq_next | NUM_LINES'(32'h0000_0005);
        else if (legacy && t == 1) irq_next = irq_next | NUM_LINES'(32'h0000_0100);
        else irq_next = irq_next | NUM_LINES'(line_bit(route_flat[t*ROUTE_W +: ROUTE_W]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_next;
  end

  assert_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !gl_en |=> (irq_q == '0));
  assert_legacy0_R8: assert property (@(posedge clk) disable iff (rst)
    (legacy && gl_en && expire[0] && ten[0]) |=> (irq_q[0] && irq_q[2]));
  assert_legacy1_R8: assert property (@(posedge clk) disable iff (rst)
    (legacy && gl_en && expire[1] && ten[1]) |=> irq_q[8]);
  assert_route_R7: assert property (@(posedge clk) disable iff (rst)
    (!legacy && gl_en && expire[0] && ten[0]) |=> irq_q[route_flat[ROUTE_W-1:0]]);
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_pkg::*;
#(
  parameter int          NUM_TIMERS = 3,
  parameter int          NUM_LINES  = 32,
  parameter int          TICK_DIV   = 1,
  parameter logic [31:0] TICK_FS    = 32'd10_000_000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_LINES-1:0] irq_pulse
);
  localparam logic [31:0] CAP = cap_word(NUM_TIMERS);

  logic [1:0]  gcfg_q;
  logic [63:0] cnt_q;
  logic        tick;
  logic [31:0] cnt_next_lo;
  logic        wr_en, in_win;
  logic [ADDR_W-1:0] rel;
  logic [4:0]  win_id, win_off;
  logic [31:0] rd_data;

  logic [NUM_TIMERS-1:0]         ch_wr_cfg, ch_wr_match, ch_expire, ch_ten;
  logic [31:0]                   ch_cfg [NUM_TIMERS];
  logic [31:0]                   ch_match [NUM_TIMERS];
  logic [NUM_TIMERS*ROUTE_W-1:0] ch_route;

  assign wr_en   = req_valid && req_write;
  assign in_win  = (req_addr[9:8] != 2'b00);
  assign rel     = req_addr - WIN_BASE;
  assign win_id  = rel[9:5];
  assign win_off = rel[4:0];

  always_ff @(posedge clk) begin
    if (rst) gcfg_q <= 2'b00;
    else if (wr_en && req_addr == OFF_GCFG) gcfg_q <= req_wdata[1:0];
  end

  evt_counter #(.TICK_DIV(TICK_DIV)) u_cnt (
    .clk(clk), .rst(rst), .en(gcfg_q[0]),
    .wr_lo(wr_en && req_addr == OFF_CNT_LO),
    .wr_hi(wr_en && req_addr == OFF_CNT_HI),
    .wdata(req_wdata), .cnt_q(cnt_q), .tick_o(tick), .cnt_next_lo(cnt_next_lo)
  );

  generate
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_ch
      assign ch_wr_cfg[t]   = wr_en && in_win && win_id == 5'(t) && win_off == WOFF_CFG;
      assign ch_wr_match[t] = wr_en && in_win && win_id == 5'(t) && win_off == WOFF_MATCH;
      evt_chan u_ch (
        .clk(clk), .rst(rst), .wr_cfg(ch_wr_cfg[t]), .wr_match(ch_wr_match[t]),
        .wdata(req_wdata), .tick(tick), .cnt_next_lo(cnt_next_lo),
        .cfg_rd(ch_cfg[t]), .match_q(ch_match[t]), .expire_o(ch_expire[t]),
        .ten_o(ch_ten[t]), .route_o(ch_route[t*ROUTE_W +: ROUTE_W])
      );
    end
  endgenerate

  evt_route #(.NUM_TIMERS(NUM_TIMERS), .NUM_LINES(NUM_LINES)) u_route (
    .clk(clk), .rst(rst), .expire(ch_expire), .ten(ch_ten), .route_flat(ch_route),
    .gl_en(gcfg_q[0]), .legacy(gcfg_q[1]), .irq_q(irq_pulse)
  );

  always_comb begin
    rd_data = 32'h0;
    if (in_win) begin
      for (int t = 0; t < NUM_TIMERS; t++) begin
        if (win_id == 5'(t)) begin
          case (win_off)
            WOFF_CFG:   rd_data = ch_cfg[t];
            WOFF_CAPS:  rd_data = CH_LINE_CAPS;
            WOFF_MATCH: rd_data = ch_match[t];
            default:    rd_data = 32'h0;
          endcase
        end
      end
    end else begin
      case (req_addr)
        OFF_CAP:    rd_data = CAP;
        OFF_PERIOD: rd_data = TICK_FS;
        OFF_GCFG:   rd_data = {30'h0, gcfg_q};
        OFF_CNT_LO: rd_data = cnt_q[31:0];
        default:    rd_data = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_data : 32'h0;
    end
  end

  assert_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_norsp_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_gcfg_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && req_addr == OFF_GCFG) |=> (gcfg_q == $past(req_wdata[1:0])));
  assert_gcfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && req_addr == OFF_GCFG) |=> $stable(gcfg_q));
endmodule

// File: tb/evt_timer_regs_tb.sv
module evt_timer_regs_tb;
  localparam int NT = 3;
  localparam int NL = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NL-1:0] irq_pulse;

  int checks = 0, failures = 0;
  int line_cnt [NL];
  int wide_err = 0;
  logic [NL-1:0] irq_prev = '0;

  logic [31:0] m_cfg [NT];
  logic [31:0] m_match [NT];
  logic [1:0]  m_g;
  logic [31:0] m_cnt;

  always #4 clk = ~clk;

  evt_timer_regs #(.NUM_TIMERS(NT), .NUM_LINES(NL), .TICK_DIV(1)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq_pulse(irq_pulse)
  );

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NL; i++) if (irq_pulse[i]) line_cnt[i]++;
      if ((irq_pulse & irq_prev) != '0) wide_err++;
      irq_prev = irq_pulse;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Tasks start and end at a falling edge: one access per cycle.
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
    checks++;
    if (rsp_valid !== 1'b1) begin
      failures++;
      $display("FAIL R10 rsp_valid actual=%b expected=1", rsp_valid);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_lines();
    for (int i = 0; i < NL; i++) line_cnt[i] = 0;
  endtask

  function automatic logic [31:0] exp_rd(input logic [9:0] a);
    logic [9:0] rel;
    int id;
    rel = a - 10'h100;
    if (a >= 10'h100) begin
      id = int'(rel >> 5);
      if (id >= NT) return 32'h0;
      case (rel[4:0])
        5'h00: return m_cfg[id] | 32'h10;
        5'h04: return 32'h0000_FFFF;
        5'h08: return m_match[id];
        default: return 32'h0;
      endcase
    end
    case (a)
      10'h000: return 32'h8086_8201;
      10'h004: return 32'h0098_9680;
      10'h010: return {30'h0, m_g};
      10'h0F0: return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit is_writable(input logic [9:0] a);
    logic [9:0] rel;
    rel = a - 10'h100;
    if (a == 10'h010 || a == 10'h0F0 || a == 10'h0F4) return 1;
    if (a >= 10'h100 && int'(rel >> 5) < NT && (rel[4:0] == 5'h00 || rel[4:0] == 5'h08)) return 1;
    return 0;
  endfunction

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, a32, start, held;
    logic [9:0]  a;
    void'($urandom(32'd2024));
    for (int t = 0; t < NT; t++) begin m_cfg[t] = 0; m_match[t] = 32'hFFFF_FFFF; end
    m_g = 0; m_cnt = 0;
    clear_lines();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // Reset state (R10)
    check("R10 irq after reset", irq_pulse, 32'h0);
    rd(10'h010, d); check("R10 config reset", d, 32'h0);
    rd(10'h0F0, d); check("R10 counter reset", d, 32'h0);
    rd(10'h108, d); check("R5 match reset", d, 32'hFFFF_FFFF);

    // Capability (R1)
    rd(10'h000, d); check("R1 cap low", d, 32'h8086_8201);
    rd(10'h004, d); check("R1 tick period", d, 32'h0098_9680);

    // Ignored writes (R2)
    wr(10'h000, 32'h1234_5678); wr(10'h014, 32'hFFFF_FFFF);
    rd(10'h000, d); check("R2 id write ignored", d, 32'h8086_8201);
    rd(10'h014, d); check("R2 config upper reads 0", d, 32'h0);
    wr(10'h010, 32'hFFFF_FFFE); m_g = 2'b10;
    rd(10'h010, d); check("R2 only bits 1:0 kept", d, 32'h2);
    wr(10'h010, 32'h0); m_g = 0;

    // Random register traffic with global enable held at 0
    for (int i = 0; i < 300; i++) begin
      int op, t;
      op = int'($urandom % 6);
      t  = int'($urandom % NT);
      d  = $urandom;
      case (op)
        0: begin wr(10'(10'h100 + t * 32), d); m_cfg[t] = d & 32'h3F0C; end
        1: begin wr(10'(10'h108 + t * 32), d); m_match[t] = d; end
        2: begin wr(10'h010, d & 32'hFFFF_FFFE); m_g = d[1:0] & 2'b10; end
        3: if (d[0]) begin wr(10'h0F0, d); m_cnt = d; end
           else begin wr(10'h0F4, d); end
        4: begin
             a32 = $urandom; a = a32[9:0] & 10'h3FC;
             rd(a, d);
             check($sformatf("R5 R6 read %h", a), d, exp_rd(a));
           end
        default: begin
             a32 = $urandom; a = a32[9:0] & 10'h3FC;
             if (!is_writable(a)) wr(a, d);
           end
      endcase
    end
    for (int t = 0; t < NT; t++) begin
      rd(10'(10'h100 + t * 32), d); check("R5 cfg readback", d, m_cfg[t] | 32'h10);
      rd(10'(10'h108 + t * 32), d); check("R5 match readback", d, m_match[t]);
    end
    rd(10'h0F0, d); check("R4 R6 counter intact", d, m_cnt);
    rd(10'h020, d); check("R6 status reads 0", d, 32'h0);
    rd(10'h160, d); check("R5 absent timer reads 0", d, 32'h0);
    check("R9 no pulses while disabled", line_cnt[0] + line_cnt[5] + line_cnt[8], 32'h0);

    // Counter write semantics (R4)
    wr(10'h0F0, 32'h0000_1000);
    wr(10'h0F4, 32'hDEAD_BEEF);
    rd(10'h0F0, d); check("R4 high write keeps low", d, 32'h0000_1000);
    rd(10'h0F4, d); check("R4 high reads 0", d, 32'h0);

    // Counting, freeze, resume (R3)
    for (int t = 0; t < NT; t++) begin wr(10'(10'h100 + t * 32), 32'h0); m_cfg[t] = 0; end
    wr(10'h0F0, 32'd500);
    wr(10'h010, 32'h1);
    rd(10'h0F0, start); check("R3 first read after enable", start, 32'd500);
    rd(10'h0F0, d); check("R3 one step per clock", d, 32'd501);
    idle(5);
    rd(10'h0F0, d); check("R3 steps over idle", d, 32'd507);
    wr(10'h010, 32'h0);
    rd(10'h0F0, held); check("R3 latched at disable", held, 32'd509);
    idle(7);
    rd(10'h0F0, d); check("R3 frozen while disabled", d, held);
    wr(10'h010, 32'h1);
    rd(10'h0F0, d); check("R3 resumes from held", d, held);
    wr(10'h010, 32'h0);

    // Routed expiry (R7)
    wr(10'h0F0, 32'd100);
    wr(10'h108, 32'd110);
    wr(10'h100, 32'h0000_0A04);   // enable, route 5
    clear_lines();
    wr(10'h010, 32'h1);
    idle(30);
    wr(10'h010, 32'h0);
    idle(2);
    check("R7 route line 5 pulses once", line_cnt[5], 32'd1);
    check("R7 other lines quiet", line_cnt[0] + line_cnt[2] + line_cnt[8], 32'h0);

    // Legacy mapping (R8)
    wr(10'h0F0, 32'd200);
    wr(10'h108, 32'd205); wr(10'h100, 32'h0000_0A04);
    wr(10'h128, 32'd207); wr(10'h120, 32'h0000_0C04);   // route 6
    clear_lines();
    wr(10'h010, 32'h3);
    idle(30);
    wr(10'h010, 32'h0);
    idle(2);
    check("R8 timer0 line 0", line_cnt[0], 32'd1);
    check("R8 timer0 line 2", line_cnt[2], 32'd1);
    check("R8 timer1 line 8", line_cnt[8], 32'd1);
    check("R8 route fields ignored", line_cnt[5] + line_cnt[6], 32'h0);

    // Gating and cancel (R9)
    wr(10'h100, 32'h0); wr(10'h120, 32'h0);
    wr(10'h0F0, 32'd300);
    wr(10'h148, 32'd305); wr(10'h140, 32'h0000_0E00);   // route 7, not enabled
    clear_lines();
    wr(10'h010, 32'h1);
    idle(20);
    wr(10'h010, 32'h0);
    idle(2);
    check("R9 disabled timer no pulse", line_cnt[7], 32'h0);
    wr(10'h0F0, 32'd400);
    wr(10'h148, 32'd450); wr(10'h140, 32'h0000_0E04);
    clear_lines();
    wr(10'h010, 32'h1);
    idle(10);
    wr(10'h010, 32'h0);
    idle(70);
    check("R9 disable cancels expiry", line_cnt[7], 32'h0);
    rd(10'h0F0, d); check("R9 counter held below match", 32'(d < 32'd450), 32'd1);

    check("R7 every pulse one clock wide", wide_err, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule